// File: doc/BRIEF.md
# Shared-Line Sharer Directory Entry

This block keeps the coherence record for a single line of a shared last-level cache. The system has N private first-level caches. The record holds four things: which caches hold a copy (a sharer bit-vector), which cache owns the line exclusively, whether the line is dirty, and the coherence state of the line, which may be stable or transient. A controller changes the record with single-cycle command pulses. Each pulse carries the ID of the requesting cache. The controller loads the state and dirty flag directly.

Several values are computed combinationally from the stored record and the current requestor:
- the signed acknowledgement count to put in a reply;
- the invalidation targets, both for a forwarded request and for a replacement;
- a flag that says the requestor is the only sharer left;
- the access permission that follows from the state.

The acknowledgement count is negative. It counts how many invalidation acknowledgements the receiver must still collect, and the requestor never acknowledges itself. Moving messages and storing line data are handled elsewhere.

Top module: `dir_line_entry`

## Requirements
- R1: While rst_n is low, the sharer vector is zero, owner_vld is 0, dirty is 0 and state is 0 (not present).
- R2: An add pulse sets the requestor's sharer bit at the next rising clock edge. A remove pulse clears that bit at the next rising clock edge. No other bit changes.
- R3: When several commands arrive in the same cycle, only one is applied, chosen in the order mark-exclusive, clear, remove, add. Clear empties the sharer vector and leaves the owner fields unchanged.
- R4: Mark-exclusive leaves only the requestor's sharer bit set, records the requestor in owner_id, and sets owner_vld to 1, all at the next edge.
- R5: sharer_cnt is the number of set sharer bits, and is_sharer is the requestor's bit.
- R6: When reply_kind is 1 (data reply), ack_cnt is minus sharer_cnt, plus one if the requestor is a sharer.
- R7: When reply_kind is 2 (upgrade acknowledgement), ack_cnt is minus sharer_cnt plus one.
- R8: When reply_kind is 0 (shared data) or 3, ack_cnt is zero.
- R9: inv_fwd_mask is the sharer vector with the requestor's bit cleared. inv_repl_mask is the full sharer vector.
- R10: State codes are: 0 not present, 1 shared, 2 modified, 3 modified-and-held-by-a-first-level-cache, and 4 to 7 transient. The permission output follows the state: state 1 gives perm 1 (read-only), state 2 gives perm 2 (read-write), state 3 gives perm 3 (stale), and every other state gives perm 0 (busy).
- R11: one_left is 1 exactly when the requestor is a sharer and sharer_cnt equals one.
- R12: state_wr loads state_in, and dirty_wr loads dirty_in, at the next edge. Both are independent of the sharer commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_mark_excl | input | 1 | Make the requestor the exclusive owner |
| cmd_clear | input | 1 | Empty the sharer vector |
| cmd_remove | input | 1 | Drop the requestor from the sharers |
| cmd_add | input | 1 | Add the requestor to the sharers |
| req_id | input | $clog2(N) | Requesting cache ID |
| reply_kind | input | 2 | Kind of reply that ack_cnt is computed for |
| state_wr | input | 1 | Load state_in |
| state_in | input | 3 | New coherence state |
| dirty_wr | input | 1 | Load dirty_in |
| dirty_in | input | 1 | New dirty flag |
| sharers | output | N | Sharer bit-vector |
| owner_id | output | $clog2(N) | Exclusive owner ID |
| owner_vld | output | 1 | Owner ID has been recorded |
| dirty | output | 1 | Dirty flag |
| state | output | 3 | Coherence state |
| sharer_cnt | output | $clog2(N+1) | Number of sharers |
| is_sharer | output | 1 | Requestor is a sharer |
| one_left | output | 1 | Requestor is the only sharer |
| ack_cnt | output | $clog2(N)+2 | Signed acknowledgement count |
| inv_fwd_mask | output | N | Invalidation targets for a forwarded request |
| inv_repl_mask | output | N | Invalidation targets for a replacement |
| perm | output | 2 | Access permission |

## Verification
The bench targets the places where the off-by-one rules are easy to get wrong.

- It asks for a data-reply count twice over the same two-sharer vector: once with a requestor that is a sharer (expected -1) and once with one that is not (expected -2). A design that ignored membership would give the same number for both.
- It drives mark-exclusive together with add, remove together with add, and clear together with remove. A wrong priority would leave extra bits set, or keep a bit that should have been dropped.
- It checks that the forwarded mask drops the requestor while the replacement mask keeps it, and that the one-left flag is false for a non-sharer.
- It walks the permission through every state code, so a swapped or missing case shows up as the wrong permission.

// File: rtl/dir_pkg.sv
`timescale 1ns/1ps
package dir_pkg;
  typedef enum logic [2:0] {
    ST_NP    = 3'd0,
    ST_SS    = 3'd1,
    ST_M     = 3'd2,
    ST_MT    = 3'd3,
    ST_TR_A  = 3'd4,
    ST_TR_B  = 3'd5,
    ST_TR_C  = 3'd6,
    ST_TR_D  = 3'd7
  } line_state_e;

  typedef enum logic [1:0] {
    PERM_BUSY  = 2'd0,
    PERM_RO    = 2'd1,
    PERM_RW    = 2'd2,
    PERM_STALE = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    RK_SHARED  = 2'd0,
    RK_DATA    = 2'd1,
    RK_UPGRADE = 2'd2,
    RK_NONE    = 2'd3
  } reply_kind_e;
endpackage

// File: rtl/dir_sharer_regs.sv
`timescale 1ns/1ps
module dir_sharer_regs #(
  parameter int N   = 8,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_mark_excl,
  input  logic           cmd_clear,
  input  logic           cmd_remove,
  input  logic           cmd_add,
  input  logic [IDW-1:0] req_id,
  input  logic           state_wr,
  input  logic [2:0]     state_in,
  input  logic           dirty_wr,
  input  logic           dirty_in,
  output logic [N-1:0]   sharers,
  output logic [IDW-1:0] owner_id,
  output logic           owner_vld,
  output logic           dirty,
  output logic [2:0]     state
);
  logic [N-1:0]   sharers_nxt;
  logic [IDW-1:0] owner_id_nxt;
  logic           owner_vld_nxt;
  logic [N-1:0]   req_onehot;
  logic           sharer_en;

  assign req_onehot = N'(1) << req_id;
  assign sharer_en  = cmd_mark_excl | cmd_clear | cmd_remove | cmd_add;

  // Priority: mark-exclusive, clear, remove, add
  always_comb begin
    sharers_nxt   = sharers;
    owner_id_nxt  = owner_id;
    owner_vld_nxt = owner_vld;
    if (cmd_mark_excl) begin
      sharers_nxt   = req_onehot;
      owner_id_nxt  = req_id;
      owner_vld_nxt = 1'b1;
    end else if (cmd_clear) begin
      sharers_nxt = '0;
    end else if (cmd_remove) begin
      sharers_nxt = sharers & ~req_onehot;
    end else if (cmd_add) begin
      sharers_nxt = sharers | req_onehot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sharers   <= '0;
      owner_id  <= '0;
      owner_vld <= 1'b0;
    end else if (sharer_en) begin
      sharers   <= sharers_nxt;
      owner_id  <= owner_id_nxt;
      owner_vld <= owner_vld_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= 3'd0;
    end else if (state_wr) begin
      state <= state_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= 1'b0;
    end else if (dirty_wr) begin
      dirty <= dirty_in;
    end
  end

  p_excl_only_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mark_excl |=> ($onehot(sharers) && sharers[$past(req_id)] &&
                       owner_vld && owner_id == $past(req_id)));

  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clear && !cmd_mark_excl) |=> (sharers == '0 && $stable(owner_id)));

  p_remove_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_remove && !cmd_clear && !cmd_mark_excl) |=> !sharers[$past(req_id)]);

  p_add_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_add && !cmd_remove && !cmd_clear && !cmd_mark_excl) |=>
      (sharers[$past(req_id)] && $countones(sharers) >= $countones($past(sharers))));

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_add || cmd_remove || cmd_clear || cmd_mark_excl) |=> $stable(sharers));
endmodule

// File: rtl/dir_ack_calc.sv
`timescale 1ns/1ps
module dir_ack_calc #(
  parameter int N   = 8,
  parameter int IDW = $clog2(N),
  parameter int CW  = $clog2(N+1),
  parameter int AW  = $clog2(N)+2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   sharers,
  input  logic [IDW-1:0] req_id,
  input  logic [1:0]     reply_kind,
  output logic [CW-1:0]  sharer_cnt,
  output logic           is_sharer,
  output logic           one_left,
  output logic [AW-1:0]  ack_cnt,
  output logic [N-1:0]   inv_fwd_mask,
  output logic [N-1:0]   inv_repl_mask
);
  import dir_pkg::*;

  logic signed [AW-1:0] cnt_s;
  logic signed [AW-1:0] ack_data;
  logic signed [AW-1:0] ack_upg;

  always_comb begin
    sharer_cnt = '0;
    for (int i = 0; i < N; i++) begin
      sharer_cnt = sharer_cnt + CW'(sharers[i]);
    end
  end

  assign is_sharer = sharers[req_id];
  assign one_left  = is_sharer && (sharer_cnt == CW'(1));

  assign cnt_s    = $signed(AW'(sharer_cnt));
  assign ack_data = -cnt_s + $signed(AW'(is_sharer));
  assign ack_upg  = -cnt_s + $signed(AW'(1));

  always_comb begin
    case (reply_kind_e'(reply_kind))
      RK_DATA:    ack_cnt = ack_data;
      RK_UPGRADE: ack_cnt = ack_upg;
      default:    ack_cnt = '0;
    endcase
  end

  assign inv_repl_mask = sharers;
  assign inv_fwd_mask  = sharers & ~(N'(1) << req_id);

  p_fwd_excludes_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_fwd_mask[req_id] && (inv_fwd_mask & ~sharers) == '0));

  p_data_nonpos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_kind == 2'd1) |-> ($signed(ack_cnt) <= 0));

  p_upg_le_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_kind == 2'd2) |-> ($signed(ack_cnt) <= 1));

  p_shared_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_kind == 2'd0) |-> (ack_cnt == '0));

  p_one_left_r11: assert property (@(posedge clk) disable iff (!rst_n)
    one_left |-> ($onehot(sharers) && sharers[req_id]));
endmodule

// File: rtl/dir_perm_map.sv
`timescale 1ns/1ps
module dir_perm_map (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] state,
  output logic [1:0] perm
);
  import dir_pkg::*;

  always_comb begin
    case (line_state_e'(state))
      ST_SS:   perm = PERM_RO;
      ST_M:    perm = PERM_RW;
      ST_MT:   perm = PERM_STALE;
      default: perm = PERM_BUSY;
    endcase
  end

  p_rw_only_mod_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (perm == 2'd2) |-> (state == 3'd2));

  p_busy_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 || state[2]) |-> (perm == 2'd0));
endmodule

// File: rtl/dir_line_entry.sv
`timescale 1ns/1ps
module dir_line_entry #(
  parameter int N   = 8,
  parameter int IDW = $clog2(N),
  parameter int CW  = $clog2(N+1),
  parameter int AW  = $clog2(N)+2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_mark_excl,
  input  logic           cmd_clear,
  input  logic           cmd_remove,
  input  logic           cmd_add,
  input  logic [IDW-1:0] req_id,
  input  logic [1:0]     reply_kind,
  input  logic           state_wr,
  input  logic [2:0]     state_in,
  input  logic           dirty_wr,
  input  logic           dirty_in,
  output logic [N-1:0]   sharers,
  output logic [IDW-1:0] owner_id,
  output logic           owner_vld,
  output logic           dirty,
  output logic [2:0]     state,
  output logic [CW-1:0]  sharer_cnt,
  output logic           is_sharer,
  output logic           one_left,
  output logic [AW-1:0]  ack_cnt,
  output logic [N-1:0]   inv_fwd_mask,
  output logic [N-1:0]   inv_repl_mask,
  output logic [1:0]     perm
);
  dir_sharer_regs #(.N(N), .IDW(IDW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_mark_excl(cmd_mark_excl), .cmd_clear(cmd_clear),
    .cmd_remove(cmd_remove), .cmd_add(cmd_add), .req_id(req_id),
    .state_wr(state_wr), .state_in(state_in),
    .dirty_wr(dirty_wr), .dirty_in(dirty_in),
    .sharers(sharers), .owner_id(owner_id), .owner_vld(owner_vld),
    .dirty(dirty), .state(state)
  );

  dir_ack_calc #(.N(N), .IDW(IDW), .CW(CW), .AW(AW)) u_ack (
    .clk(clk), .rst_n(rst_n),
    .sharers(sharers), .req_id(req_id), .reply_kind(reply_kind),
    .sharer_cnt(sharer_cnt), .is_sharer(is_sharer), .one_left(one_left),
    .ack_cnt(ack_cnt), .inv_fwd_mask(inv_fwd_mask),
    .inv_repl_mask(inv_repl_mask)
  );

  dir_perm_map u_perm (
    .clk(clk), .rst_n(rst_n), .state(state), .perm(perm)
  );

  p_state_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    state_wr |=> (state == $past(state_in)));

  p_dirty_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_wr |=> (dirty == $past(dirty_in)));
endmodule

// File: tb/dir_line_entry_tb.sv
`timescale 1ns/1ps
module dir_line_entry_tb_top;
  localparam int N   = 8;
  localparam int IDW = $clog2(N);
  localparam int CW  = $clog2(N+1);
  localparam int AW  = $clog2(N)+2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cmd_mark_excl, cmd_clear, cmd_remove, cmd_add;
  logic [IDW-1:0] req_id;
  logic [1:0]     reply_kind;
  logic           state_wr, dirty_wr, dirty_in;
  logic [2:0]     state_in;
  logic [N-1:0]   sharers, inv_fwd_mask, inv_repl_mask;
  logic [IDW-1:0] owner_id;
  logic           owner_vld, dirty, is_sharer, one_left;
  logic [2:0]     state;
  logic [CW-1:0]  sharer_cnt;
  logic [AW-1:0]  ack_cnt;
  logic [1:0]     perm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dir_line_entry #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_mark_excl(cmd_mark_excl), .cmd_clear(cmd_clear),
    .cmd_remove(cmd_remove), .cmd_add(cmd_add), .req_id(req_id),
    .reply_kind(reply_kind), .state_wr(state_wr), .state_in(state_in),
    .dirty_wr(dirty_wr), .dirty_in(dirty_in),
    .sharers(sharers), .owner_id(owner_id), .owner_vld(owner_vld),
    .dirty(dirty), .state(state), .sharer_cnt(sharer_cnt),
    .is_sharer(is_sharer), .one_left(one_left), .ack_cnt(ack_cnt),
    .inv_fwd_mask(inv_fwd_mask), .inv_repl_mask(inv_repl_mask), .perm(perm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    cmd_mark_excl = 0; cmd_clear = 0; cmd_remove = 0; cmd_add = 0;
    state_wr = 0; dirty_wr = 0;
  endtask

  // Apply a command bundle for one cycle; return at a falling edge after update
  task automatic pulse(input bit mx, input bit cl, input bit rm, input bit ad,
                       input int id);
    @(negedge clk);
    cmd_mark_excl = mx; cmd_clear = cl; cmd_remove = rm; cmd_add = ad;
    req_id = IDW'(id);
    @(negedge clk);
    idle();
  endtask

  task automatic look(input int id, input int kind);
    req_id = IDW'(id); reply_kind = 2'(kind);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 sharers", int'(sharers), 0);
    chk("R1 owner_vld", int'(owner_vld), 0);
    chk("R1 state", int'(state), 0);
    chk("R1 dirty", int'(dirty), 0);
    chk("R10 perm np", int'(perm), 0);
  endtask

  task automatic t_add_and_acks();
    pulse(0, 0, 0, 1, 2);
    pulse(0, 0, 0, 1, 5);
    chk("R2 add", int'(sharers), 'h24);
    look(5, 1);
    chk("R5 cnt", int'(sharer_cnt), 2);
    chk("R5 is_sharer", int'(is_sharer), 1);
    chk("R6 data sharer", int'($signed(ack_cnt)), -1);
    look(0, 1);
    chk("R6 data nonsharer", int'($signed(ack_cnt)), -2);
    look(0, 2);
    chk("R7 upgrade", int'($signed(ack_cnt)), -1);
    look(5, 0);
    chk("R8 shared", int'($signed(ack_cnt)), 0);
    look(5, 3);
    chk("R8 kind3", int'($signed(ack_cnt)), 0);
    look(5, 1);
    chk("R9 fwd", int'(inv_fwd_mask), 'h04);
    chk("R9 repl", int'(inv_repl_mask), 'h24);
    chk("R11 two sharers", int'(one_left), 0);
  endtask

  task automatic t_remove_one_left();
    pulse(0, 0, 1, 0, 2);
    chk("R2 remove", int'(sharers), 'h20);
    look(5, 1);
    chk("R11 one left", int'(one_left), 1);
    look(2, 1);
    chk("R11 nonsharer", int'(one_left), 0);
    look(5, 1);
    chk("R6 single self", int'($signed(ack_cnt)), 0);
  endtask

  task automatic t_priority();
    pulse(1, 0, 0, 1, 3);
    chk("R4 excl vec", int'(sharers), 'h08);
    chk("R4 owner", int'(owner_id), 3);
    chk("R4 owner_vld", int'(owner_vld), 1);
    pulse(0, 0, 1, 1, 6);
    chk("R3 remove over add", int'(sharers), 'h08);
    pulse(0, 0, 0, 1, 6);
    chk("R2 add 6", int'(sharers), 'h48);
    pulse(1, 0, 0, 0, 1);
    chk("R4 excl clears others", int'(sharers), 'h02);
    pulse(0, 1, 1, 0, 4);
    chk("R3 clear", int'(sharers), 0);
    chk("R3 clear keeps owner", int'(owner_id), 1);
    chk("R3 clear keeps vld", int'(owner_vld), 1);
    pulse(1, 1, 1, 1, 7);
    chk("R3 excl over all", int'(sharers), 'h80);
  endtask

  task automatic t_perm_dirty();
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      state_wr = 1; state_in = 3'(s);
      @(negedge clk);
      idle();
      chk("R12 state", int'(state), s);
      chk("R10 perm", int'(perm), (s == 1) ? 1 : (s == 2) ? 2 : (s == 3) ? 3 : 0);
    end
    @(negedge clk);
    dirty_wr = 1; dirty_in = 1; cmd_clear = 1;
    @(negedge clk);
    idle();
    chk("R12 dirty", int'(dirty), 1);
    chk("R12 clear alongside", int'(sharers), 0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    req_id = '0; reply_kind = '0; state_in = '0; dirty_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_add_and_acks();
    t_remove_one_left();
    t_priority();
    t_perm_dirty();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule